// File: doc/BRIEF.md
# Pixel-Doubling Framebuffer VGA Scanout

This block drives a VGA display at 640 by 480 from an image of 320 by 240 pixels held in on-chip memory. It runs column and line counters over the full raster, including the blanking intervals, and drives both sync pulses active low. While the counters are inside the visible area, it issues a read to the framebuffer.

Each stored pixel fills a 2 by 2 square on screen. The buffer coordinate is the screen coordinate halved, and the top-left pixel of the image is at (0,0). A read address is the base address plus an offset built from fixed bit fields. Bit 0 is always zero, the buffer x coordinate sits in bits 9:1 and the buffer y coordinate sits in bits 17:10.

The memory returns a 16-bit word one enabled cycle after the address. That word holds 5 bits of red, 6 bits of green and 5 bits of blue. The block widens each component to 8 bits and delays the sync signals by the same number of stages, so that colour and timing leave the block together. A pixel-clock enable sets the scan rate, so a single fast clock can drive the block. All screen timing values are parameters.

Top module: `vga_pixdbl_scan`

## Requirements
- R1: While `rst_n` is low, all three colour outputs are 0, `vga_hs` and `vga_vs` are 1, and `mem_rd` is 0.
- R2: The column counter runs from 0 to H_TOTAL-1 and then returns to 0, where H_TOTAL = H_VIS+H_FP+H_SYNC+H_BP (default 800). The line counter advances by one when the column wraps and returns to 0 after line V_TOTAL-1 (default 525). Each counter moves only on a cycle with `pix_ce` high.
- R3: For a scan position (column h, line v), `vga_hs` is 0 exactly when H_VIS+H_FP <= h < H_VIS+H_FP+H_SYNC, and `vga_vs` is 0 exactly when V_VIS+V_FP <= v < V_VIS+V_FP+V_SYNC.
- R4: For a visible position, `mem_addr` = BASE + (v>>1)*1024 + (h>>1)*2. This means bit 0 is zero, buffer x is in bits 9:1 and buffer y is in bits 17:10. Screen columns 2k and 2k+1, and screen lines 2j and 2j+1, give the same address.
- R5: `mem_rd` is 1 exactly on cycles where the block is out of reset, `pix_ce` is 1 and the current scan position is visible (h < H_VIS and v < V_VIS).
- R6: The framebuffer word is split into red = bits 15:11, green = bits 10:5 and blue = bits 4:0. Each output is 8 bits wide: red = {r5, r5[4:2]}, green = {g6, g6[5:4]} and blue = {b5, b5[4:2]}.
- R7: The scan starts at (0,0) once `rst_n` has been high for two clock edges. The outputs for a scan position appear two enabled cycles after its address was presented. After the k-th enabled edge of the scan, the outputs show position k-2. After the first enabled edge they still show the idle state: black, both syncs high.
- R8: At positions outside the visible area, the colour outputs are 0.
- R9: On a clock edge with `pix_ce` low, no output changes and the scan position stays where it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_ce | input | 1 | Pixel-clock enable; one scan position per high cycle |
| mem_addr | output | 32 | Framebuffer byte address of the current scan position |
| mem_rd | output | 1 | Read strobe to the framebuffer |
| mem_rdata | input | 16 | Framebuffer word, valid one enabled cycle after the address |
| vga_hs | output | 1 | Horizontal sync, active low |
| vga_vs | output | 1 | Vertical sync, active low |
| vga_r | output | 8 | Red output |
| vga_g | output | 8 | Green output |
| vga_b | output | 8 | Blue output |

## Verification
The framebuffer model returns a word that is a scrambled function of the address. A fetch for the wrong coordinate, or with a swapped x or y field, therefore shows up as wrong colour bits, and unequal red, green and blue values expose any mix-up in the field split.

The scan is run first with the enable held high for more than two frames, which covers column wrap, line wrap and frame wrap. It is then run with sparse and irregular enable patterns. Those patterns separate a pipeline that is correctly gated by the enable from one that advances on every clock, and they show whether the two-stage alignment between address and colour holds.

A reduced raster keeps the frames short, but the blanking and sync windows it exercises are defined exactly as in the full raster.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

  localparam int X_LSB = 1;
  localparam int X_W   = 9;
  localparam int Y_W   = 8;

  typedef struct packed {
    logic [4:0] r;
    logic [5:0] g;
    logic [4:0] b;
  } rgb565_t;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb888_t;

  function automatic rgb888_t widen565(rgb565_t p);
    rgb888_t o;
    o.r = {p.r, p.r[4:2]};
    o.g = {p.g, p.g[5:4]};
    o.b = {p.b, p.b[4:2]};
    return o;
  endfunction

endpackage

// File: rtl/vga_timing_ctr.sv
module vga_timing_ctr #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int HW     = 10,
  parameter int VW     = 10
) (
  input  logic          clk,
  input  logic          run_n,
  input  logic          adv,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          vis,
  output logic          hs_n,
  output logic          vs_n
);

  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HS_BEG  = H_VIS + H_FP;
  localparam int HS_END  = HS_BEG + H_SYNC;
  localparam int VS_BEG  = V_VIS + V_FP;
  localparam int VS_END  = VS_BEG + V_SYNC;

  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic          h_last, v_last;

  assign h_last = (h_q == HW'(H_TOTAL - 1));
  assign v_last = (v_q == VW'(V_TOTAL - 1));

  always_comb begin
    h_d = h_q;
    v_d = v_q;
    if (adv) begin
      if (h_last) begin
        h_d = '0;
        v_d = v_last ? '0 : v_q + VW'(1);
      end else begin
        h_d = h_q + HW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign h_cnt = h_q;
  assign v_cnt = v_q;
  assign vis   = (h_q < HW'(H_VIS)) && (v_q < VW'(V_VIS));
  assign hs_n  = !((h_q >= HW'(HS_BEG)) && (h_q < HW'(HS_END)));
  assign vs_n  = !((v_q >= VW'(VS_BEG)) && (v_q < VW'(VS_END)));

endmodule

// File: rtl/vga_addr_gen.sv
module vga_addr_gen
  import vga_scan_pkg::*;
#(
  parameter int          AW   = 32,
  parameter logic [31:0] BASE = 32'h0800_0000,
  parameter int          HW   = 10,
  parameter int          VW   = 10
) (
  input  logic [HW-1:0] h_cnt,
  input  logic [VW-1:0] v_cnt,
  output logic [AW-1:0] addr
);

  localparam int OFS_W = Y_W + X_W + X_LSB;

  logic [X_W-1:0]   buf_x;
  logic [Y_W-1:0]   buf_y;
  logic [OFS_W-1:0] ofs;

  always_comb begin
    buf_x = X_W'(h_cnt >> 1);
    buf_y = Y_W'(v_cnt >> 1);
    ofs   = {buf_y, buf_x, {X_LSB{1'b0}}};
    addr  = AW'(BASE) + AW'(ofs);
  end

endmodule

// File: rtl/vga_color_stage.sv
module vga_color_stage
  import vga_scan_pkg::*;
(
  input  logic        clk,
  input  logic        run_n,
  input  logic        adv,
  input  logic        vis_in,
  input  logic        hs_in,
  input  logic        vs_in,
  input  logic [15:0] rdata,
  output logic        out_vis,
  output logic        hs_out,
  output logic        vs_out,
  output rgb888_t     rgb_out
);

  logic    vis1_q, hs1_q, vs1_q;
  logic    vis1_d, hs1_d, vs1_d;
  logic    vis2_q, hs2_q, vs2_q;
  logic    vis2_d, hs2_d, vs2_d;
  rgb888_t rgb_q, rgb_d;

  always_comb begin
    vis1_d = vis1_q;
    hs1_d  = hs1_q;
    vs1_d  = vs1_q;
    vis2_d = vis2_q;
    hs2_d  = hs2_q;
    vs2_d  = vs2_q;
    rgb_d  = rgb_q;
    if (adv) begin
      vis1_d = vis_in;
      hs1_d  = hs_in;
      vs1_d  = vs_in;
      vis2_d = vis1_q;
      hs2_d  = hs1_q;
      vs2_d  = vs1_q;
      rgb_d  = vis1_q ? widen565(rgb565_t'(rdata)) : '0;
    end
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      vis1_q <= 1'b0;
      hs1_q  <= 1'b1;
      vs1_q  <= 1'b1;
      vis2_q <= 1'b0;
      hs2_q  <= 1'b1;
      vs2_q  <= 1'b1;
      rgb_q  <= '0;
    end else begin
      vis1_q <= vis1_d;
      hs1_q  <= hs1_d;
      vs1_q  <= vs1_d;
      vis2_q <= vis2_d;
      hs2_q  <= hs2_d;
      vs2_q  <= vs2_d;
      rgb_q  <= rgb_d;
    end
  end

  assign out_vis = vis2_q;
  assign hs_out  = hs2_q;
  assign vs_out  = vs2_q;
  assign rgb_out = rgb_q;

endmodule

// File: rtl/vga_pixdbl_scan.sv
module vga_pixdbl_scan
  import vga_scan_pkg::*;
#(
  parameter int          H_VIS  = 640,
  parameter int          H_FP   = 16,
  parameter int          H_SYNC = 96,
  parameter int          H_BP   = 48,
  parameter int          V_VIS  = 480,
  parameter int          V_FP   = 10,
  parameter int          V_SYNC = 2,
  parameter int          V_BP   = 33,
  parameter int          AW     = 32,
  parameter logic [31:0] BASE   = 32'h0800_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_ce,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [15:0]   mem_rdata,
  output logic          vga_hs,
  output logic          vga_vs,
  output logic [7:0]    vga_r,
  output logic [7:0]    vga_g,
  output logic [7:0]    vga_b
);

  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);

  logic [1:0]    rs_q, rs_d;
  logic          run;
  logic          adv;
  logic [HW-1:0] scan_h;
  logic [VW-1:0] scan_v;
  logic          scan_vis, scan_hs, scan_vs;
  logic          out_vis;
  rgb888_t       rgb;

  // reset release synchroniser
  always_comb rs_d = {rs_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= rs_d;
  end

  assign run = rs_q[1];
  assign adv = run & pix_ce;

  vga_timing_ctr #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HW(HW), .VW(VW)
  ) u_tmg (
    .clk   (clk),
    .run_n (run),
    .adv   (adv),
    .h_cnt (scan_h),
    .v_cnt (scan_v),
    .vis   (scan_vis),
    .hs_n  (scan_hs),
    .vs_n  (scan_vs)
  );

  vga_addr_gen #(
    .AW(AW), .BASE(BASE), .HW(HW), .VW(VW)
  ) u_adr (
    .h_cnt (scan_h),
    .v_cnt (scan_v),
    .addr  (mem_addr)
  );

  assign mem_rd = adv & scan_vis;

  vga_color_stage u_col (
    .clk     (clk),
    .run_n   (run),
    .adv     (adv),
    .vis_in  (scan_vis),
    .hs_in   (scan_hs),
    .vs_in   (scan_vs),
    .rdata   (mem_rdata),
    .out_vis (out_vis),
    .hs_out  (vga_hs),
    .vs_out  (vga_vs),
    .rgb_out (rgb)
  );

  assign vga_r = rgb.r;
  assign vga_g = rgb.g;
  assign vga_b = rgb.b;

endmodule

// File: rtl/vga_scan_chk.sv
module vga_scan_chk #(
  parameter int H_TOTAL = 800,
  parameter int V_TOTAL = 525,
  parameter int H_VIS   = 640,
  parameter int V_VIS   = 480,
  parameter int HW      = 10,
  parameter int VW      = 10,
  parameter int AW      = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          pix_ce,
  input logic [HW-1:0] scan_h,
  input logic [VW-1:0] scan_v,
  input logic          scan_vis,
  input logic [AW-1:0] mem_addr,
  input logic          mem_rd,
  input logic          out_vis,
  input logic          vga_hs,
  input logic          vga_vs,
  input logic [7:0]    vga_r,
  input logic [7:0]    vga_g,
  input logic [7:0]    vga_b
);

  AST_H_WRAP: assert property (@(posedge clk) disable iff (!run)
    (pix_ce && scan_h == HW'(H_TOTAL - 1)) |=> (scan_h == '0)); // R2

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!run)
    (pix_ce && scan_h == HW'(H_TOTAL - 1) && scan_v != VW'(V_TOTAL - 1))
      |=> (scan_v == $past(scan_v) + VW'(1))); // R2

  AST_ADDR_PAIR: assert property (@(posedge clk) disable iff (!run)
    (pix_ce && scan_vis && !scan_h[0] && scan_h != HW'(H_TOTAL - 1))
      |=> (mem_addr == $past(mem_addr))); // R4

  AST_RD_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (scan_h < HW'(H_VIS) && scan_v < VW'(V_VIS))); // R5

  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vis |-> (vga_r == '0 && vga_g == '0 && vga_b == '0)); // R8

  AST_HOLD_NO_CE: assert property (@(posedge clk) disable iff (!run)
    !pix_ce |=> ($stable(scan_h) && $stable(scan_v) && $stable(vga_hs) &&
                 $stable(vga_vs) && $stable(vga_r) && $stable(vga_g) &&
                 $stable(vga_b))); // R9

endmodule

bind vga_pixdbl_scan vga_scan_chk #(
  .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .H_VIS(H_VIS), .V_VIS(V_VIS),
  .HW(HW), .VW(VW), .AW(AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .pix_ce   (pix_ce),
  .scan_h   (scan_h),
  .scan_v   (scan_v),
  .scan_vis (scan_vis),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .out_vis  (out_vis),
  .vga_hs   (vga_hs),
  .vga_vs   (vga_vs),
  .vga_r    (vga_r),
  .vga_g    (vga_g),
  .vga_b    (vga_b)
);

// File: tb/test_vga_pixdbl_scan.sv
module test_vga_pixdbl_scan;

  localparam int HV = 16, HF = 2, HS = 3, HB = 3;
  localparam int VV = 8,  VF = 1, VS = 2, VB = 1;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam logic [31:0] BASE = 32'h0800_0000;

  typedef struct {
    logic       hs, vs, vis;
    logic [7:0] r, g, b;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_ce = 1'b1;
  logic [31:0] mem_addr;
  logic        mem_rd;
  logic [15:0] mem_rdata = 16'h0;
  logic        vga_hs, vga_vs;
  logic [7:0]  vga_r, vga_g, vga_b;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;
  int   rel = 0;
  int   nce = 0;
  int   ph = 0, pv = 0;
  bit   last_ce = 1'b0;
  exp_t q[$];
  logic [25:0] prev_out;
  bit   prev_ok = 1'b0;

  always #5 clk = ~clk;

  vga_pixdbl_scan #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) i_vga_pixdbl_scan (
    .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .vga_hs(vga_hs), .vga_vs(vga_vs),
    .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b)
  );

  function automatic logic [15:0] fb_word(logic [31:0] a);
    logic [15:0] k;
    k = {a[17:10], a[8:1]};
    return k * 16'd40503 + 16'h1D3B;
  endfunction

  function automatic logic [31:0] exp_addr(int h, int v);
    return BASE + 32'((v / 2) * 1024) + 32'((h / 2) * 2);
  endfunction

  function automatic bit is_vis(int h, int v);
    return (h < HV) && (v < VV);
  endfunction

  // framebuffer model: one enabled cycle of read latency
  always @(posedge clk)
    if (mem_rd) mem_rdata <= fb_word(mem_addr);

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: pushes the expected output item for each position the scan presents
  always @(posedge clk) begin
    if (!rst_n) rel = 0;
    else if (rel < 10) rel++;
    last_ce = (rel >= 3) && pix_ce;
    if (last_ce) begin
      exp_t e;
      logic [15:0] w;
      w     = fb_word(exp_addr(ph, pv));
      e.vis = is_vis(ph, pv);
      e.hs  = !(ph >= HV + HF && ph < HV + HF + HS);
      e.vs  = !(pv >= VV + VF && pv < VV + VF + VS);
      e.r   = e.vis ? {w[15:11], w[15:13]} : 8'h0;
      e.g   = e.vis ? {w[10:5], w[10:9]}   : 8'h0;
      e.b   = e.vis ? {w[4:0], w[4:2]}     : 8'h0;
      q.push_back(e);
      nce++;
      if (ph == HT - 1) begin
        ph = 0;
        pv = (pv == VT - 1) ? 0 : pv + 1;
      end else begin
        ph++;
      end
    end
  end

  // monitor: compares the ports against the scoreboard
  always @(negedge clk) begin
    logic [25:0] cur;
    cur = {vga_hs, vga_vs, vga_r, vga_g, vga_b};
    if (!rst_n) begin
      check(cur == {2'b11, 24'h0} && !mem_rd, "R1", "reset outputs",
            {cur, mem_rd}, {2'b11, 24'h0, 1'b0});
    end else begin
      bit exp_rd;
      exp_rd = (rel >= 2) && pix_ce && is_vis(ph, pv);
      check(mem_rd == exp_rd, "R5", "mem_rd", mem_rd, exp_rd);
      if (rel >= 2 && is_vis(ph, pv))
        check(mem_addr == exp_addr(ph, pv), "R4", "mem_addr", mem_addr, exp_addr(ph, pv));
      if (nce > 0) begin
        if (last_ce) begin
          if (nce == 1) begin
            check(cur == {2'b11, 24'h0}, "R7", "idle before first pixel", cur, {2'b11, 24'h0});
          end else begin
            exp_t e;
            logic [25:0] ev;
            e  = q.pop_front();
            ev = {e.hs, e.vs, e.r, e.g, e.b};
            if (e.vis) check(cur == ev, "R6 R7", "visible pixel", cur, ev);
            else       check(cur == ev, "R3 R8 R2", "blanking", cur, ev);
          end
        end else if (prev_ok) begin
          check(cur == prev_out, "R9", "hold with pix_ce low", cur, prev_out);
        end
      end
      prev_out = cur;
      prev_ok  = 1'b1;
    end
  end

  task automatic step(bit ce);
    @(posedge clk);
    #2 pix_ce = ce;
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    // continuous enable: more than two full frames (R2 wraps)
    for (int i = 0; i < 700; i++) step(1'b1);
    // sparse enable, one cycle in three (R9)
    for (int i = 0; i < 900; i++) step(i % 3 == 0);
    // irregular enable pattern
    for (int i = 0; i < 900; i++) step((i % 7 != 3) && (i % 5 != 1));
    step(1'b1);
    repeat (3) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

endmodule